// File: doc/BRIEF.md
# Dual-Channel Result Readout Port

This block holds the latest pair of 16-bit results from a two-channel simultaneous-sampling converter and hands them to a host. The host reads them in one of two ways. In word mode it reads one channel at a time on a 16-bit bus, with an optional exchange of the two bytes. In stream mode both results leave on a single serial line as one 32-bit frame, most significant bit first. The host picks which channel goes first.

Stream mode can run from a clock the block makes itself (master) or from a clock the host supplies (slave). In master mode a code selects the clock rate, and a framing strobe with selectable polarity marks the frame. The result input is a valid-only stream. The block accepts a pair on every cycle that `res_valid` is high, so it applies no back-pressure. A new pair replaces the stored pair and, in stream mode, starts a new frame.

Top module: `dual_result_port`

## Requirements
- R1: With `ser_mode` low, `par_oe` is all ones. With `ser_mode` high, `par_oe` is all zeros, and the bus pins (including the two lowest) are released.
- R2: In word mode with `byte_swap` low, `par_data[15:8]` carries the high byte and `par_data[7:0]` carries the low byte. With `byte_swap` high, the two bytes trade places.
- R3: In word mode, `chan_sel` high presents channel A and `chan_sel` low presents channel B.
- R4: A stream frame has 32 bits, sent MSB first. With `chan_sel` high the frame is A then B. With `chan_sel` low it is B then A.
- R5: In master mode (`ext_clk_sel` low), `sclk_out` has a period of 2^(N+1) clock cycles, where N is `div_code` (0 to 3). `sclk_out` idles low. `sdout` changes only after a falling edge of `sclk_out`, so it is stable at each rising edge.
- R6: In master mode, `sync_out` is at its active level for the whole frame: high when `sync_inv` is 0, low when `sync_inv` is 1. At all other times it sits at the inactive level.
- R7: In slave mode (`ext_clk_sel` high), `sdout` advances one bit after each synchronized rising edge of `ext_sclk`. `sclk_out` stays low, `sync_out` stays inactive, and `div_code` has no effect.
- R8: A pair is latched on a cycle with `res_valid` high. It is held unchanged until the next such cycle, whatever the readout mode.
- R9: A pair accepted while `ser_mode` is high starts a frame one cycle later. `res_valid` is never refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Result pair valid; always accepted |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| ser_mode | input | 1 | 0 word bus, 1 serial stream |
| byte_swap | input | 1 | Exchange bytes on word bus |
| chan_sel | input | 1 | Word: 1 A / 0 B. Stream: 1 A first / 0 B first |
| ext_clk_sel | input | 1 | 0 master clock, 1 slave on ext_sclk |
| div_code | input | 2 | Master clock divide code N |
| sync_inv | input | 1 | 0 frame strobe active high, 1 active low |
| ext_sclk | input | 1 | Host-supplied serial clock (slave) |
| par_data | output | 16 | Word bus data |
| par_oe | output | 16 | Per-bit drive enable for the word bus |
| sdout | output | 1 | Serial data |
| sclk_out | output | 1 | Generated serial clock (master) |
| sync_out | output | 1 | Frame strobe |

## Verification
On every cycle the assertions check the following:
- the stored pair does not change without a strobe;
- the shift register stays still when no frame is running;
- the bit counter never passes 32;
- the generated clock stays low while idle and in slave mode;
- the bus enables are released in stream mode.

Only the bench scenarios can show the rest: the actual bit order and content of each frame, the clock period for each divide code, the strobe polarity over a whole frame, the byte exchange, and channel selection on the word bus.

// File: rtl/dual_result_port_pkg.sv
package dual_result_port_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DIV_W  = 2;
  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
  } res_pair_t;
endpackage

// File: rtl/drp_word_mux.sv
module drp_word_mux #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic         sel_a,
  input  logic         swap,
  input  logic         ser_mode,
  output logic [W-1:0] data,
  output logic [W-1:0] oe
);
  localparam int unsigned HB = W / 2;
  logic [W-1:0] pick;

  always_comb begin
    pick = sel_a ? word_a : word_b;
    data = swap ? {pick[HB-1:0], pick[W-1:HB]} : pick;
    oe   = ser_mode ? '0 : '1;
  end
endmodule

// File: rtl/drp_ser_engine.sv
module drp_ser_engine #(
  parameter int unsigned W    = 16,
  parameter int unsigned DIVW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [W-1:0]    first_w,
  input  logic [W-1:0]    second_w,
  input  logic            ext_mode,
  input  logic [DIVW-1:0] div_code,
  input  logic            sync_inv,
  input  logic            ext_sclk,
  output logic            sdout,
  output logic            sclk_out,
  output logic            sync_out
);
  localparam int unsigned FW  = 2 * W;
  localparam int unsigned CW  = $clog2(FW + 1);
  localparam int unsigned HCW = 2 ** DIVW;

  logic [FW-1:0]  shreg;
  logic [CW-1:0]  bitcnt;
  logic [HCW-1:0] divcnt, half_m1;
  logic           active, sclk_q;
  logic [2:0]     es_sync;
  logic           ext_rise;

  assign half_m1  = (HCW'(1) << div_code) - HCW'(1);
  assign ext_rise = es_sync[1] & ~es_sync[2];

  always_ff @(posedge clk) begin
    if (!rst_n) es_sync <= '0;
    else        es_sync <= {es_sync[1:0], ext_sclk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0; bitcnt <= '0; divcnt <= '0; active <= 1'b0; sclk_q <= 1'b0;
    end else if (start) begin
      shreg <= {first_w, second_w}; bitcnt <= '0; divcnt <= '0;
      active <= 1'b1; sclk_q <= 1'b0;
    end else if (active && ext_mode) begin
      sclk_q <= 1'b0;
      if (ext_rise) begin
        shreg  <= shreg << 1;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CW'(FW - 1)) active <= 1'b0;
      end
    end else if (active) begin
      if (divcnt == half_m1) begin
        divcnt <= '0;
        sclk_q <= ~sclk_q;
        if (sclk_q) begin
          shreg  <= shreg << 1;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == CW'(FW - 1)) active <= 1'b0;
        end
      end else begin
        divcnt <= divcnt + 1'b1;
      end
    end
  end

  assign sdout    = shreg[FW-1];
  assign sclk_out = sclk_q & active & ~ext_mode;
  assign sync_out = (active & ~ext_mode) ? ~sync_inv : sync_inv;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CW'(FW));
  p_idle_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> $stable(shreg));
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk_out);
  p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (!sclk_out && sync_out == sync_inv));
endmodule

// File: rtl/dual_result_port.sv
module dual_result_port
  import dual_result_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  input  logic              ser_mode,
  input  logic              byte_swap,
  input  logic              chan_sel,
  input  logic              ext_clk_sel,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              sync_inv,
  input  logic              ext_sclk,
  output logic [WORD_W-1:0] par_data,
  output logic [WORD_W-1:0] par_oe,
  output logic              sdout,
  output logic              sclk_out,
  output logic              sync_out
);
  res_pair_t held;
  logic      start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0; start_q <= 1'b0;
    end else begin
      if (res_valid) held <= '{a: res_a, b: res_b};
      start_q <= res_valid & ser_mode;
    end
  end

  drp_word_mux #(.W(WORD_W)) u_mux (
    .word_a(held.a), .word_b(held.b), .sel_a(chan_sel), .swap(byte_swap),
    .ser_mode(ser_mode), .data(par_data), .oe(par_oe)
  );

  drp_ser_engine #(.W(WORD_W), .DIVW(DIV_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start_q),
    .first_w (chan_sel ? held.a : held.b),
    .second_w(chan_sel ? held.b : held.a),
    .ext_mode(ext_clk_sel), .div_code(div_code), .sync_inv(sync_inv),
    .ext_sclk(ext_sclk), .sdout(sdout), .sclk_out(sclk_out), .sync_out(sync_out)
  );

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(held));
  p_oe_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode |-> par_oe == '0);
endmodule

// File: tb/dual_result_port_tb_top.sv
module dual_result_port_tb_top;
  logic clk = 0, rst_n = 0;
  logic res_valid = 0;
  logic [15:0] res_a = 0, res_b = 0;
  logic ser_mode = 0, byte_swap = 0, chan_sel = 0, ext_clk_sel = 0;
  logic [1:0] div_code = 0;
  logic sync_inv = 0, ext_sclk = 0;
  logic [15:0] par_data, par_oe;
  logic sdout, sclk_out, sync_out;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dual_result_port dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); res_a = a; res_b = b; res_valid = 1;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic t_reset;
    chk(par_oe == 16'hFFFF, "R1 reset oe", par_oe, 16'hFFFF);
    chk(par_data == 0, "R8 reset data", par_data, 0);
    chk(sync_out == 0 && sclk_out == 0, "R6 reset idle", {sync_out, sclk_out}, 0);
  endtask

  task automatic t_parallel;
    ser_mode = 0;
    load(16'hA1B2, 16'hC3D4);
    chan_sel = 1; byte_swap = 0; #1;
    chk(par_data == 16'hA1B2, "R3 chan A", par_data, 16'hA1B2);
    chan_sel = 0; #1;
    chk(par_data == 16'hC3D4, "R3 chan B", par_data, 16'hC3D4);
    byte_swap = 1; #1;
    chk(par_data == 16'hD4C3, "R2 swap B", par_data, 16'hD4C3);
    chan_sel = 1; #1;
    chk(par_data == 16'hB2A1, "R2 swap A", par_data, 16'hB2A1);
    byte_swap = 0;
    @(negedge clk); res_a = 16'h0F0F; res_b = 16'h1111;
    repeat (3) @(negedge clk);
    chk(par_data == 16'hA1B2, "R8 hold without strobe", par_data, 16'hA1B2);
    chk(par_oe == 16'hFFFF, "R1 word oe", par_oe, 16'hFFFF);
  endtask

  task automatic t_master(input logic [1:0] n, input bit a_first, input bit inv,
                          input logic [15:0] a, input logic [15:0] b);
    logic [31:0] got, exp;
    int rises, last_t, t, per_bad;
    bit prev, sync_bad;
    ser_mode = 1; ext_clk_sel = 0; div_code = n; chan_sel = a_first; sync_inv = inv;
    exp = a_first ? {a, b} : {b, a};
    got = 0; rises = 0; last_t = -1; per_bad = 0; prev = 0; sync_bad = 0; t = 0;
    load(a, b);
    chk(par_oe == 0, "R1 serial oe", par_oe, 0);
    while (rises < 32 && t < 2000) begin
      @(negedge clk); t++;
      if (sync_out != !inv) sync_bad = 1;
      if (sclk_out && !prev) begin
        got = {got[30:0], sdout};
        if (last_t >= 0 && t - last_t != (2 << n)) per_bad++;
        last_t = t; rises++;
      end
      prev = sclk_out;
    end
    chk(got == exp, "R4 frame content/order", got, exp);
    chk(per_bad == 0, "R5 sclk period", per_bad, 0);
    chk(!sync_bad, "R6 sync active in frame", sync_bad, 0);
    repeat (20) @(negedge clk);
    chk(sync_out == inv && sclk_out == 0, "R6 sync inactive after frame", {sync_out, sclk_out}, {inv, 1'b0});
  endtask

  task automatic t_slave(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] got, exp;
    bit quiet_bad;
    ser_mode = 1; ext_clk_sel = 1; div_code = 3; chan_sel = 0; sync_inv = 1;
    exp = {b, a}; got = 0; quiet_bad = 0;
    load(a, b);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      got = {got[30:0], sdout};
      ext_sclk = 1;
      repeat (4) begin @(negedge clk); if (sclk_out || sync_out != 1) quiet_bad = 1; end
      ext_sclk = 0;
      repeat (4) @(negedge clk);
    end
    chk(got == exp, "R7 slave frame", got, exp);
    chk(!quiet_bad, "R7 slave sclk/sync quiet", quiet_bad, 0);
  endtask

  task automatic t_restart;
    ser_mode = 1; ext_clk_sel = 0; div_code = 0; sync_inv = 0; chan_sel = 1;
    load(16'h8000, 16'h0000);
    @(negedge clk);
    chk(sync_out == 1, "R9 frame starts next cycle", sync_out, 1);
    chk(sdout == 1, "R9 MSB presented", sdout, 1);
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_parallel();
    t_master(0, 1, 0, 16'h1234, 16'hFEDC);
    t_master(2, 0, 1, 16'h5A5A, 16'h8001);
    t_master(3, 1, 1, 16'hFFFF, 16'h0000);
    t_slave(16'hBEEF, 16'h7E01);
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule